// File: doc/BRIEF.md
# Debug Event Trigger State Sequencer

This block is a small programmable sequencer for on-chip debug. It watches three single-cycle comparator match strobes, called M0, M1 and M2, and walks through four states: State1, State2, State3 and Final. When it reaches Final it raises a one-cycle trigger, which the surrounding debug logic uses as a breakpoint or trace-stop request.

Each of the three non-final states has its own 4-bit transition code. A code can define up to three transitions out of its state:
- a forward step on one event or an OR of events;
- an optional direct jump to Final;
- an optional return to State1 on a reset event.

With these codes the sequencer can detect ordered patterns rather than a single match. Examples are "M0 arrives after M2 before M1 does", "the third occurrence of an event with no reset event in between", and "event A does not occur between two occurrences of B or C".

Software programs the three codes through a small write port while the sequencer is disarmed, then raises the arm input. Dropping arm returns the sequencer to State1, ready for the next run.

Top module: `dbg_event_sequencer`

## Requirements
- R1: While rst_n is low, the following hold: `seq_state` reads 0 (State1), `trigger` is 0, and all three transition codes are cleared to 0000.
- R2: While `arm` is low at a clock edge, the sequencer goes to State1 and `trigger` stays 0, whatever `match` carries. State encoding: 0=State1, 1=State2, 2=State3, 3=Final.
- R3: A write (`cfg_we` high) stores `cfg_code` into the code of State1, State2 or State3 for `cfg_sel` values 0, 1 or 2. The write is ignored while `arm` is high, and it is ignored for `cfg_sel`=3.
- R4: The `match` bit positions are: bit0=M0, bit1=M1, bit2=M2. The forward codes step to the next state as follows: 0001 on M0, 0010 on M1, 0011 on M2, 0100 on M0|M1, and 1111 on any match. Here "next" after State1 is State2, and after State2 is State3.
- R5: From State3, any forward step leads to Final. The direct jump codes go to Final from any non-final state: 0101 on M0, 0110 on M1, 0111 on M2, and 1000 on M0|M1.
- R6: Some codes add a reset event that returns the sequencer to State1. The combined codes are:
  - 1001: M2 steps forward, M1 resets.
  - 1010: M0 steps forward, M1 resets.
  - 1011: M0 jumps to Final, M1 resets.
  - 1100: M0|M1 jumps to Final, M2 resets.
  - 1101: M0|M1 steps forward, M2 resets.
  - 1110: M1 steps forward, M2 resets.
- R7: When several matches arrive in the same cycle, priority is: reaching Final first, then reset to State1, then the forward step.
- R8: `trigger` is high for exactly the one cycle in which `seq_state` first shows Final. While armed, the sequencer stays in Final whatever the matches are.
- R9: Code 0000 defines no transition, so the sequencer holds its state under any match. With no match at all, an armed sequencer holds its state.
- R10: After Final, the sequencer leaves only through disarm, which returns it to State1. A new arm then starts a fresh sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | High: sequencer runs; low: held in State1, codes writable |
| cfg_we | input | 1 | Transition-code write strobe |
| cfg_sel | input | 2 | Code select: 0=State1, 1=State2, 2=State3 |
| cfg_code | input | 4 | Transition code to write |
| match | input | 3 | Comparator strobes, bit0=M0, bit1=M1, bit2=M2 |
| seq_state | output | 2 | Current state, 0..3 = State1, State2, State3, Final |
| trigger | output | 1 | One-cycle pulse on entry into Final |

## Verification
The sequencer is run through several ordered event patterns:
- A two-step M2 chain that must end on M0, interrupted once by an M1 reset.
- An "M0 before M1 after M2" pattern, taken both through the reset path and through the trigger path.
- A "no M2 between two M0/M1 events" pattern.
- A third-occurrence count in which M0 and M2 strobe together.

Simultaneous strobes separate the three priority levels: Final beats reset, and reset beats forward. The remaining tests target other faults:
- Idle and catch-all codes.
- Writes made while armed, and writes to the unused select value, which expose a wrong write gate or a wrong decode.
- Repeated matches in Final followed by a disarm, which check that the trigger is a single pulse and that the exit path is correct.

// File: rtl/dbg_seq_pkg.sv
// Package: shared types and the transition-code decode for the debug
// event sequencer. Assumes three match events and 4-bit codes.
package dbg_seq_pkg;

    localparam int EVT_W  = 3;
    localparam int CODE_W = 4;
    localparam int NUM_SCR = 3;

    typedef enum logic [1:0] {
        ST_ONE   = 2'd0,
        ST_TWO   = 2'd1,
        ST_THREE = 2'd2,
        ST_FINAL = 2'd3
    } seq_state_e;

    // Decoded meaning of one transition code
    typedef struct packed {
        logic [EVT_W-1:0] fwd_mask;  // events that move forward
        logic             fwd_fin;   // forward goes straight to Final
        logic [EVT_W-1:0] rst_mask;  // events that return to State1
    } trans_t;

    // Map a 4-bit code to its transitions (bit0=M0, bit1=M1, bit2=M2)
    function automatic trans_t decode_code(input logic [CODE_W-1:0] code);
        trans_t t;
        t = '0;
        case (code)
            4'b0001: t.fwd_mask = 3'b001;
            4'b0010: t.fwd_mask = 3'b010;
            4'b0011: t.fwd_mask = 3'b100;
            4'b0100: t.fwd_mask = 3'b011;
            4'b0101: begin t.fwd_mask = 3'b001; t.fwd_fin = 1'b1; end
            4'b0110: begin t.fwd_mask = 3'b010; t.fwd_fin = 1'b1; end
            4'b0111: begin t.fwd_mask = 3'b100; t.fwd_fin = 1'b1; end
            4'b1000: begin t.fwd_mask = 3'b011; t.fwd_fin = 1'b1; end
            4'b1001: begin t.fwd_mask = 3'b100; t.rst_mask = 3'b010; end
            4'b1010: begin t.fwd_mask = 3'b001; t.rst_mask = 3'b010; end
            4'b1011: begin t.fwd_mask = 3'b001; t.fwd_fin = 1'b1; t.rst_mask = 3'b010; end
            4'b1100: begin t.fwd_mask = 3'b011; t.fwd_fin = 1'b1; t.rst_mask = 3'b100; end
            4'b1101: begin t.fwd_mask = 3'b011; t.rst_mask = 3'b100; end
            4'b1110: begin t.fwd_mask = 3'b010; t.rst_mask = 3'b100; end
            4'b1111: t.fwd_mask = 3'b111;
            default: t = '0;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/dbg_scr_bank.sv
// Module: bank of per-state transition-code registers.
// Assumes: writes accepted only while disarmed; select values beyond
// NUM_SCR-1 address nothing. Synchronous active-low reset clears all codes.
module dbg_scr_bank #(
    parameter int NUM_SCR = 3,
    parameter int CODE_W  = 4,
    localparam int SEL_W  = $clog2(NUM_SCR + 1)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            armed,
    input  logic                            wr_en,
    input  logic [SEL_W-1:0]                wr_sel,
    input  logic [CODE_W-1:0]               wr_code,
    output logic [NUM_SCR-1:0][CODE_W-1:0]  codes
);

    for (genvar g = 0; g < NUM_SCR; g++) begin : g_scr
        // Hold one state's code; load on an unarmed write that selects it
        always_ff @(posedge clk) begin
            if (!rst_n)
                codes[g] <= '0;
            else if (wr_en && !armed && (wr_sel == SEL_W'(g)))
                codes[g] <= wr_code;
        end
    end

endmodule

// File: rtl/dbg_seq_step.sv
// Module: combinational next-state logic for one sequencer step.
// Assumes: state ST_FINAL is absorbing; priority is Final, then reset to
// State1, then forward step. Forward from State3 always lands in Final.
module dbg_seq_step
    import dbg_seq_pkg::*;
#(
    parameter int EVT_W_P  = EVT_W,
    parameter int CODE_W_P = CODE_W
) (
    input  seq_state_e          cur,
    input  logic [CODE_W_P-1:0] code,
    input  logic [EVT_W_P-1:0]  match,
    output seq_state_e          nxt
);

    trans_t tr;
    logic   hit_fwd;
    logic   hit_rst;
    logic   to_final;

    // Decode the code and find which transitions the strobes hit
    always_comb begin
        tr       = decode_code(code);
        hit_fwd  = |(match & tr.fwd_mask);
        hit_rst  = |(match & tr.rst_mask);
        to_final = hit_fwd && (tr.fwd_fin || cur == ST_THREE);
    end

    // Choose the next state by fixed priority
    always_comb begin
        if (cur == ST_FINAL)
            nxt = ST_FINAL;
        else if (to_final)
            nxt = ST_FINAL;
        else if (hit_rst)
            nxt = ST_ONE;
        else if (hit_fwd)
            nxt = seq_state_e'(cur + 2'd1);
        else
            nxt = cur;
    end

endmodule

// File: rtl/dbg_event_sequencer.sv
// Module: top of the debug event trigger sequencer.
// Tracks ordered comparator matches through State1..State3 and pulses
// trigger on entry to Final. Assumes single-cycle match strobes and that
// codes are written while disarmed. Synchronous active-low reset.
module dbg_event_sequencer
    import dbg_seq_pkg::*;
#(
    parameter int EVT_NUM  = EVT_W,
    parameter int CODE_BITS = CODE_W,
    parameter int SCR_NUM  = NUM_SCR,
    localparam int SEL_W   = $clog2(SCR_NUM + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 arm,
    input  logic                 cfg_we,
    input  logic [SEL_W-1:0]     cfg_sel,
    input  logic [CODE_BITS-1:0] cfg_code,
    input  logic [EVT_NUM-1:0]   match,
    output logic [1:0]           seq_state,
    output logic                 trigger
);

    logic [SCR_NUM-1:0][CODE_BITS-1:0] codes;
    logic [CODE_BITS-1:0]              cur_code;
    seq_state_e                        state_q;
    seq_state_e                        state_d;
    logic                              trig_q;

    dbg_scr_bank #(
        .NUM_SCR (SCR_NUM),
        .CODE_W  (CODE_BITS)
    ) i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .armed   (arm),
        .wr_en   (cfg_we),
        .wr_sel  (cfg_sel),
        .wr_code (cfg_code),
        .codes   (codes)
    );

    // Pick the code that belongs to the current state
    always_comb begin
        cur_code = '0;
        for (int i = 0; i < SCR_NUM; i++)
            if (state_q == seq_state_e'(i))
                cur_code = codes[i];
    end

    dbg_seq_step #(
        .EVT_W_P  (EVT_NUM),
        .CODE_W_P (CODE_BITS)
    ) i_step (
        .cur   (state_q),
        .code  (cur_code),
        .match (match),
        .nxt   (state_d)
    );

    // Advance the sequence while armed; park in State1 otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_ONE;
        else if (!arm)
            state_q <= ST_ONE;
        else
            state_q <= state_d;
    end

    // Pulse trigger once on the step into Final
    always_ff @(posedge clk) begin
        if (!rst_n)
            trig_q <= 1'b0;
        else
            trig_q <= arm && (state_d == ST_FINAL) && (state_q != ST_FINAL);
    end

    assign seq_state = state_q;
    assign trigger   = trig_q;

endmodule

// File: rtl/dbg_event_sequencer_chk.sv
// Module: assertion checker for dbg_event_sequencer, bound to the top.
// Assumes the state encoding 0..3 = State1, State2, State3, Final.
module dbg_event_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       arm,
    input logic [2:0] match,
    input logic [1:0] seq_state,
    input logic       trigger
);

    // R2: disarm parks the sequencer in State1
    a_r2_disarm_parks: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> seq_state == 2'd0);

    // R2: no trigger follows a disarmed cycle
    a_r2_disarm_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> !trigger);

    // R8: trigger lasts a single cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        trigger |=> !trigger);

    // R8: trigger coincides with the first cycle in Final
    a_r8_entry_only: assert property (@(posedge clk) disable iff (!rst_n)
        trigger |-> (seq_state == 2'd3 && $past(seq_state) != 2'd3));

    // R8: Final holds while armed
    a_r8_final_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && seq_state == 2'd3) |=> seq_state == 2'd3);

    // R9: armed with no strobes, state does not move
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && match == 3'b000) |=> $stable(seq_state));

endmodule

bind dbg_event_sequencer dbg_event_sequencer_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .match     (match),
    .seq_state (seq_state),
    .trigger   (trigger)
);

// File: tb/test_dbg_event_sequencer.sv
// Bench: table-driven vectors for dbg_event_sequencer, then directed tests
// for reset behaviour.
module test_dbg_event_sequencer;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       arm;
    logic       cfg_we;
    logic [1:0] cfg_sel;
    logic [3:0] cfg_code;
    logic [2:0] match;
    logic [1:0] seq_state;
    logic       trigger;

    int n_vec  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    dbg_event_sequencer i_dbg_event_sequencer (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_code  (cfg_code),
        .match     (match),
        .seq_state (seq_state),
        .trigger   (trigger)
    );

    // Vector: req[21:18] we[17] sel[16:15] code[14:11] arm[10] match[9:7]
    // exp_state[6:5] exp_trig[4] spare[3:0]
    function automatic logic [21:0] V(input int rq, input logic we,
        input logic [1:0] sel, input logic [3:0] code, input logic a,
        input logic [2:0] m, input logic [1:0] st, input logic tr);
        return {4'(rq), we, sel, code, a, m, st, tr, 4'd0};
    endfunction

    localparam int NV = 53;
    localparam logic [21:0] VECS [NV] = '{
        // R3 program pattern: M2, M2 (M1 resets), then M0
        V(3, 1, 0, 4'h3, 0, 3'b000, 0, 0),
        V(3, 1, 1, 4'h9, 0, 3'b000, 0, 0),
        V(3, 1, 2, 4'hA, 0, 3'b000, 0, 0),
        V(9, 0, 0, 4'h0, 1, 3'b000, 0, 0),   // R9
        V(4, 0, 0, 4'h0, 1, 3'b100, 1, 0),   // R4
        V(6, 0, 0, 4'h0, 1, 3'b010, 0, 0),   // R6
        V(4, 0, 0, 4'h0, 1, 3'b100, 1, 0),
        V(4, 0, 0, 4'h0, 1, 3'b100, 2, 0),
        V(5, 0, 0, 4'h0, 1, 3'b001, 3, 1),   // R5
        V(8, 0, 0, 4'h0, 1, 3'b000, 3, 0),   // R8
        V(8, 0, 0, 4'h0, 1, 3'b010, 3, 0),
        V(10, 0, 0, 4'h0, 0, 3'b000, 0, 0),  // R10
        // M0 before M1 after M2
        V(3, 1, 1, 4'hB, 0, 3'b000, 0, 0),
        V(4, 0, 0, 4'h0, 1, 3'b100, 1, 0),
        V(6, 0, 0, 4'h0, 1, 3'b010, 0, 0),
        V(4, 0, 0, 4'h0, 1, 3'b100, 1, 0),
        V(5, 0, 0, 4'h0, 1, 3'b001, 3, 1),
        V(10, 0, 0, 4'h0, 0, 3'b000, 0, 0),
        // R7 Final beats reset
        V(4, 0, 0, 4'h0, 1, 3'b100, 1, 0),
        V(7, 0, 0, 4'h0, 1, 3'b011, 3, 1),
        V(10, 0, 0, 4'h0, 0, 3'b000, 0, 0),
        // R7 reset beats forward
        V(3, 1, 1, 4'h9, 0, 3'b000, 0, 0),
        V(4, 0, 0, 4'h0, 1, 3'b100, 1, 0),
        V(7, 0, 0, 4'h0, 1, 3'b110, 0, 0),
        V(2, 0, 0, 4'h0, 0, 3'b111, 0, 0),   // R2
        // no M2 between two M0/M1 events
        V(3, 1, 0, 4'h4, 0, 3'b000, 0, 0),
        V(3, 1, 1, 4'hC, 0, 3'b000, 0, 0),
        V(4, 0, 0, 4'h0, 1, 3'b010, 1, 0),
        V(6, 0, 0, 4'h0, 1, 3'b100, 0, 0),
        V(4, 0, 0, 4'h0, 1, 3'b001, 1, 0),
        V(7, 0, 0, 4'h0, 1, 3'b101, 3, 1),
        V(10, 0, 0, 4'h0, 0, 3'b000, 0, 0),
        // R3 write while armed ignored
        V(3, 1, 0, 4'h0, 1, 3'b000, 0, 0),
        V(3, 0, 0, 4'h0, 1, 3'b010, 1, 0),
        V(10, 0, 0, 4'h0, 0, 3'b000, 0, 0),
        // R3 select 3 ignored
        V(3, 1, 3, 4'h0, 0, 3'b000, 0, 0),
        V(3, 0, 0, 4'h0, 1, 3'b001, 1, 0),
        V(10, 0, 0, 4'h0, 0, 3'b000, 0, 0),
        // third coincident M0/M2 strobe triggers
        V(3, 1, 0, 4'h3, 0, 3'b000, 0, 0),
        V(3, 1, 1, 4'h9, 0, 3'b000, 0, 0),
        V(3, 1, 2, 4'hA, 0, 3'b000, 0, 0),
        V(4, 0, 0, 4'h0, 1, 3'b101, 1, 0),
        V(4, 0, 0, 4'h0, 1, 3'b101, 2, 0),
        V(9, 0, 0, 4'h0, 1, 3'b000, 2, 0),
        V(5, 0, 0, 4'h0, 1, 3'b101, 3, 1),
        V(10, 0, 0, 4'h0, 0, 3'b000, 0, 0),
        // R9 code 0000 holds
        V(3, 1, 0, 4'h0, 0, 3'b000, 0, 0),
        V(9, 0, 0, 4'h0, 1, 3'b111, 0, 0),
        V(9, 0, 0, 4'h0, 1, 3'b111, 0, 0),
        V(10, 0, 0, 4'h0, 0, 3'b000, 0, 0),
        // R4 catch-all code
        V(3, 1, 0, 4'hF, 0, 3'b000, 0, 0),
        V(4, 0, 0, 4'h0, 1, 3'b010, 1, 0),
        V(10, 0, 0, 4'h0, 0, 3'b000, 0, 0)
    };

    task automatic check(input string req, input logic [1:0] exp_st,
                         input logic exp_tr);
        n_vec++;
        if (seq_state !== exp_st || trigger !== exp_tr) begin
            n_fail++;
            $display("FAIL %s: state=%0d trig=%0b expected state=%0d trig=%0b",
                     req, seq_state, trigger, exp_st, exp_tr);
        end
    endtask

    task automatic step(input logic a, input logic [2:0] m);
        @(negedge clk);
        arm = a; match = m; cfg_we = 1'b0;
        @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0; arm = 1'b0; cfg_we = 1'b0; cfg_sel = '0;
        cfg_code = '0; match = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", 2'd0, 1'b0);                  // r1_ reset state
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            cfg_we   = VECS[i][17];
            cfg_sel  = VECS[i][16:15];
            cfg_code = VECS[i][14:11];
            arm      = VECS[i][10];
            match    = VECS[i][9:7];
            @(posedge clk);
            #1;
            check($sformatf("R%0d vec%0d", VECS[i][21:18], i),
                  VECS[i][6:5], VECS[i][4]);
        end

        // R1: reset mid-run clears state and the codes
        step(1'b1, 3'b010);                        // code F: State1 -> State2
        check("R4", 2'd1, 1'b0);
        @(negedge clk); rst_n = 1'b0; match = '0;
        @(posedge clk); #1;
        check("R1", 2'd0, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        step(1'b1, 3'b111);                        // cleared code: no move
        check("R1", 2'd0, 1'b0);
        step(1'b1, 3'b111);
        check("R9", 2'd0, 1'b0);
        step(1'b0, 3'b000);
        check("R10", 2'd0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule